// File: doc/BRIEF.md
# AVI Infoframe Packet Builder

This block assembles the auxiliary video information packet that a display transmitter sends with each video mode. The current mode is given as a pixel clock in kHz, a horizontal resolution and a vertical resolution. A one-cycle start pulse makes the block latch these values and derive two fields from them. The colorimetry field selects standard-definition colour coding for pixel clocks up to 27 MHz and high-definition coding above that. The picture aspect field selects 4:3 or 16:9 by comparing the width-to-height ratio against a fixed threshold. The block then walks the packet once to form the checksum, and afterwards streams the 17 bytes out through a valid/ready byte interface.

The same start pulse with the vendor selector raised streams a fixed 19-byte vendor-specific packet instead. That packet needs no checksum pass. A downstream packetiser consumes the stream and places the bytes into the link's auxiliary data periods.

Top module: `avi_packet_gen`

## Requirements
- R1: After reset, `pkt_valid_o` and `busy_o` are low and no byte is offered until a start pulse arrives.
- R2: The AVI packet byte sequence is: byte 0 = 0x82, byte 1 = 0x02, byte 2 = 0x0D, byte 4 = 0x12, byte 6 = 0x88, and bytes 7 to 16 = 0x00.
- R3: Colorimetry bits in byte 5: 0x40 when the latched pixel clock is at most 27000 kHz, 0x80 when it is higher.
- R4: Aspect bits in byte 5: 0x18 (4:3) when floor(xres*100/yres) < 156, otherwise 0x28 (16:9). The bits are ORed with the colorimetry bits.
- R5: Byte 3 is a checksum chosen so that all 17 AVI bytes sum to 0 modulo 256.
- R6: Bytes leave in index order, one per cycle where valid and ready are both high. `pkt_last_o` is high only on the final byte (index 16 for AVI). While valid is high and ready is low, data and last hold steady.
- R7: With `vendor_sel_i` high at start, the stream is 19 bytes: 0x81, 0x01, 0x06, 0x29, 0x03, 0x0C, 0x00, 0x40, then eleven 0x00. Last is flagged on byte 18.
- R8: A start pulse while `busy_o` is high is ignored. The packet in progress keeps the packet type and mode values latched at its own start.
- R9: A yres of zero gives the 16:9 aspect bits (0x28) and the packet still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to build and send a packet |
| vendor_sel_i | input | 1 | At start: 1 sends the vendor packet, 0 the AVI packet |
| pclk_khz_i | input | PCLK_W | Pixel clock in kHz |
| xres_i | input | RES_W | Active pixels per line |
| yres_i | input | RES_W | Active lines per frame |
| pkt_ready_i | input | 1 | Consumer accepts the offered byte |
| pkt_valid_o | output | 1 | A packet byte is offered |
| pkt_data_o | output | 8 | Offered byte |
| pkt_last_o | output | 1 | Offered byte is the final one of the packet |
| busy_o | output | 1 | A packet is being built or sent |

## Verification
The assertions assume that the consumer may lower ready at any time. They also assume that start may arrive in any state. Mode inputs are sampled only in the cycle a start is accepted, so they may change freely at other times. The stimulus throttles ready with a pattern that varies per packet and changes the mode inputs while a packet is in flight. It also fires extra start pulses during streaming, so each assumption is exercised rather than avoided.

// File: rtl/avi_packet_gen.sv
module avi_packet_gen #(
  parameter int PCLK_W       = 20,
  parameter int RES_W        = 12,
  parameter int SD_LIMIT_KHZ = 27000,
  parameter int RATIO_LIMIT  = 156,
  parameter int AVI_LEN      = 17,
  parameter int VSI_LEN      = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              vendor_sel_i,
  input  logic [PCLK_W-1:0] pclk_khz_i,
  input  logic [RES_W-1:0]  xres_i,
  input  logic [RES_W-1:0]  yres_i,
  input  logic              pkt_ready_i,
  output logic              pkt_valid_o,
  output logic [7:0]        pkt_data_o,
  output logic              pkt_last_o,
  output logic              busy_o
);

  localparam int IDX_W  = $clog2(VSI_LEN + 1);
  localparam int PROD_W = RES_W + 8;

  typedef enum logic [1:0] {S_IDLE, S_SUM, S_SEND} state_t;

  state_t            state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              vendor_q;
  logic [7:0]        field_q;
  logic [7:0]        acc_q;
  logic [7:0]        csum_q;
  logic [7:0]        cur_byte;
  logic [7:0]        new_field;
  logic              narrow;
  logic [PROD_W-1:0] x_scaled;
  logic [PROD_W-1:0] y_scaled;
  logic [IDX_W-1:0]  last_idx;
  logic              fire;
  logic              accept;

  assign x_scaled  = PROD_W'(xres_i) * PROD_W'(100);
  assign y_scaled  = PROD_W'(yres_i) * PROD_W'(RATIO_LIMIT);
  assign narrow    = (yres_i != '0) && (x_scaled < y_scaled);
  assign new_field = ((pclk_khz_i <= PCLK_W'(SD_LIMIT_KHZ)) ? 8'h40 : 8'h80)
                   | (narrow ? 8'h18 : 8'h28);

  assign last_idx    = vendor_q ? IDX_W'(VSI_LEN - 1) : IDX_W'(AVI_LEN - 1);
  assign pkt_valid_o = (state_q == S_SEND);
  assign pkt_last_o  = pkt_valid_o && (idx_q == last_idx);
  assign pkt_data_o  = pkt_valid_o ? cur_byte : 8'h00;
  assign busy_o      = (state_q != S_IDLE);
  assign fire        = pkt_valid_o && pkt_ready_i;
  assign accept      = (state_q == S_IDLE) && start_i;

  always_comb begin
    cur_byte = 8'h00;
    if (vendor_q) begin
      case (idx_q)
        IDX_W'(0): cur_byte = 8'h81;
        IDX_W'(1): cur_byte = 8'h01;
        IDX_W'(2): cur_byte = 8'h06;
        IDX_W'(3): cur_byte = 8'h29;
        IDX_W'(4): cur_byte = 8'h03;
        IDX_W'(5): cur_byte = 8'h0C;
        IDX_W'(7): cur_byte = 8'h40;
        default:   cur_byte = 8'h00;
      endcase
    end else begin
      case (idx_q)
        IDX_W'(0): cur_byte = 8'h82;
        IDX_W'(1): cur_byte = 8'h02;
        IDX_W'(2): cur_byte = 8'h0D;
        IDX_W'(3): cur_byte = csum_q;
        IDX_W'(4): cur_byte = 8'h12;
        IDX_W'(5): cur_byte = field_q;
        IDX_W'(6): cur_byte = 8'h88;
        default:   cur_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      vendor_q <= 1'b0;
      field_q  <= 8'h00;
      acc_q    <= 8'h00;
      csum_q   <= 8'h00;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          vendor_q <= vendor_sel_i;
          field_q  <= new_field;
          acc_q    <= 8'h00;
          csum_q   <= 8'h00;
          idx_q    <= '0;
          state_q  <= vendor_sel_i ? S_SEND : S_SUM;
        end
        S_SUM: begin
          if (idx_q == IDX_W'(AVI_LEN - 1)) begin
            csum_q  <= 8'h00 - (acc_q + cur_byte);
            idx_q   <= '0;
            state_q <= S_SEND;
          end else begin
            acc_q <= acc_q + cur_byte;
            idx_q <= idx_q + 1'b1;
          end
        end
        S_SEND: if (fire) begin
          if (pkt_last_o) begin
            idx_q   <= '0;
            state_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic [7:0] tx_sum_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_sum_q <= 8'h00;
    else if (accept) tx_sum_q <= 8'h00;
    else if (fire)   tx_sum_q <= tx_sum_q + pkt_data_o;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !pkt_valid_o);

  a_r5_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pkt_last_o && !vendor_q) |-> (8'(tx_sum_q + pkt_data_o) == 8'h00));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_last_o)));

  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_last_o |-> pkt_valid_o);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(fire && pkt_last_o)) |=> (busy_o && $stable(vendor_q) && $stable(field_q)));

  a_r2_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && idx_q == '0) |-> (pkt_data_o == (vendor_q ? 8'h81 : 8'h82)));

endmodule

// File: tb/test_avi_packet_gen.sv
module test_avi_packet_gen;
  localparam int PCLK_W = 20;
  localparam int RES_W  = 12;
  localparam int NVEC   = 8;

  localparam int V_PCLK [NVEC] = '{25175, 27000, 27001, 74250, 148500, 27000, 74250, 40000};
  localparam int V_X    [NVEC] = '{640,   720,   720,   1280,  1920,   1559,  1560,  800};
  localparam int V_Y    [NVEC] = '{480,   576,   480,   720,   1080,   1000,  1000,  0};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              vendor_sel_i = 1'b0;
  logic [PCLK_W-1:0] pclk_khz_i = '0;
  logic [RES_W-1:0]  xres_i = '0;
  logic [RES_W-1:0]  yres_i = '0;
  logic              pkt_ready_i = 1'b0;
  logic              pkt_valid_o;
  logic [7:0]        pkt_data_o;
  logic              pkt_last_o;
  logic              busy_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] got [32];
  int ngot;
  int last_at;
  bit hold_bad;

  always #2.5 clk = ~clk;

  avi_packet_gen i_avi_packet_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vendor_sel_i(vendor_sel_i),
    .pclk_khz_i(pclk_khz_i), .xres_i(xres_i), .yres_i(yres_i),
    .pkt_ready_i(pkt_ready_i), .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o),
    .pkt_last_o(pkt_last_o), .busy_o(busy_o));

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  // send one packet; optionally inject a spurious start mid-stream
  task automatic run_pkt(input bit vend, input int pclk, input int x, input int y,
                         input int pat, input bit inject);
    logic [7:0] prev_d;
    bit prev_stall;
    ngot = 0; last_at = -1; hold_bad = 0; prev_stall = 0; prev_d = 0;
    @(negedge clk);
    vendor_sel_i = vend; pclk_khz_i = PCLK_W'(pclk);
    xres_i = RES_W'(x); yres_i = RES_W'(y); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    pclk_khz_i = '0; xres_i = RES_W'(4095); yres_i = RES_W'(1); vendor_sel_i = ~vend;
    for (int k = 0; k < 400 && last_at < 0; k++) begin
      pkt_ready_i = ((k + pat) % 3) != 0;
      start_i = inject && (k == 25);
      #1;
      if (prev_stall && (!pkt_valid_o || pkt_data_o != prev_d)) hold_bad = 1;
      if (pkt_valid_o && pkt_ready_i) begin
        got[ngot] = pkt_data_o;
        if (pkt_last_o) last_at = ngot;
        ngot++;
      end
      prev_stall = pkt_valid_o && !pkt_ready_i;
      prev_d = pkt_data_o;
      @(negedge clk);
    end
    start_i = 1'b0;
    pkt_ready_i = 1'b0;
  endtask

  task automatic check_avi(input int pclk, input int x, input int y, input string tag);
    logic [7:0] e5;
    logic [7:0] s;
    e5 = (pclk <= 27000) ? 8'h40 : 8'h80;
    e5 |= (y != 0 && (x * 100) / y < 156) ? 8'h18 : 8'h28;
    chk(ngot == 17 && last_at == 16, {"R6 length/last ", tag}, last_at, 16);
    chk(got[0] == 8'h82 && got[1] == 8'h02 && got[2] == 8'h0D && got[4] == 8'h12 && got[6] == 8'h88,
        {"R2 header ", tag}, {got[0], got[1], got[2]}, 24'h82020D);
    chk(got[5][7:6] == e5[7:6], {"R3 colorimetry ", tag}, got[5], e5);
    chk(got[5] == e5, {"R4 aspect ", tag}, got[5], e5);
    s = 0;
    for (int i = 0; i < 17; i++) s += got[i];
    chk(s == 8'h00, {"R5 checksum ", tag}, s, 0);
    s = 0;
    for (int i = 7; i < 17; i++) s |= got[i];
    chk(s == 8'h00, {"R2 zero tail ", tag}, s, 0);
    chk(!hold_bad, {"R6 stall hold ", tag}, hold_bad, 0);
  endtask

  initial begin
    #12;
    chk(!pkt_valid_o && !busy_o, "R1 in reset", {pkt_valid_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pkt_valid_o && !busy_o, "R1 after reset", {pkt_valid_o, busy_o}, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_pkt(1'b0, V_PCLK[v], V_X[v], V_Y[v], v, 1'b0);
      check_avi(V_PCLK[v], V_X[v], V_Y[v], $sformatf("vec%0d", v));
    end

    // R9: yres zero
    run_pkt(1'b0, 20000, 640, 0, 1, 1'b0);
    chk(got[5] == 8'h68, "R9 yres zero", got[5], 8'h68);

    // R7: vendor packet
    run_pkt(1'b1, 74250, 1280, 720, 2, 1'b0);
    chk(ngot == 19 && last_at == 18, "R7 vendor length", last_at, 18);
    begin
      logic [7:0] ev [19];
      int bad;
      ev = '{8'h81, 8'h01, 8'h06, 8'h29, 8'h03, 8'h0C, 8'h00, 8'h40,
             8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      bad = -1;
      for (int i = 0; i < 19; i++) if (got[i] != ev[i] && bad < 0) bad = i;
      chk(bad < 0, "R7 vendor bytes", bad, -1);
    end

    // R8: spurious start during streaming (with vendor select flipped)
    run_pkt(1'b0, 74250, 1280, 720, 0, 1'b1);
    check_avi(74250, 1280, 720, "R8 inject");
    repeat (3) @(negedge clk);
    chk(!busy_o && !pkt_valid_o, "R8 no extra packet", busy_o, 0);

    // R8: vendor packet, spurious start mid-stream
    run_pkt(1'b1, 25000, 640, 480, 1, 1'b1);
    chk(ngot == 19 && got[0] == 8'h81 && got[7] == 8'h40, "R8 vendor inject", got[0], 8'h81);

    finish_run();
  end
endmodule